// File: doc/BRIEF.md
# Instruction Fetch Front End with Squash

This block is the first stage of a five-stage 32-bit pipeline. It owns the program counter and drives it as the read address of a combinational instruction memory port. On every clock edge it latches the returned word, together with the address of the following sequential instruction, into the fetch/decode pipeline register. It never looks at the instruction bits. It passes them on unchanged for decode to interpret.

The next counter value comes from one of three sources: the sequential successor, a branch target, or a jump target. The decode stage resolves control transfers one cycle after fetch. It supplies the targets and their select lines. When decode reports a jump or a taken branch, the word fetched in that cycle is on the wrong path. The block replaces it with an all-zero no-operation word in the pipeline register, so a redirect costs exactly one squashed slot. A stall input freezes the counter and the pipeline register. A redirect overrides a stall.

Top module: `fetch_front`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, the program counter is 0x00000000 and both pipeline register fields (`ifid_pc_plus4_o`, `ifid_instr_o`) are all-zero.
- R2: `imem_addr_o` always equals the current program counter, with no register between them.
- R3: With stall, branch-taken and jump all low, one clock edge moves the counter from P to P+4. The same edge loads the pipeline register with link field P+4 and, bit for bit, the word `imem_rdata_i` presented while the address was P.
- R4: With branch-taken high and jump low, one clock edge loads the counter with `br_target_i` and loads both pipeline register fields with all-zero, which is the no-operation encoding.
- R5: With jump high, one clock edge loads the counter with `jmp_target_i`, whatever branch-taken and its target are, and loads both pipeline register fields with all-zero.
- R6: With stall high and both branch-taken and jump low, the counter and both pipeline register fields keep their values across the edge.
- R7: A redirect (R4 or R5) takes effect in full even when stall is high in the same cycle.
- R8: Sequential advance wraps modulo 2^32, so the successor of 0xFFFFFFFC is 0x00000000 and the link field it records is 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| stall_i | input | 1 | Freeze the counter and the pipeline register |
| br_taken_i | input | 1 | Decode resolved a taken branch |
| br_target_i | input | 32 | Branch destination address |
| jmp_i | input | 1 | Decode holds an unconditional jump |
| jmp_target_i | input | 32 | Jump destination address |
| imem_addr_o | output | 32 | Instruction memory read address (current counter) |
| imem_rdata_i | input | 32 | Instruction word returned in the same cycle |
| ifid_pc_plus4_o | output | 32 | Pipeline register: address after the fetched one |
| ifid_instr_o | output | 32 | Pipeline register: fetched instruction or no-operation |

## Verification
The memory address is combinational, so the bench checks it in the same cycle the counter changes. Every other result is due exactly one clock edge after the control inputs that cause it. The bench applies each stimulus on a falling edge and lets one rising edge pass. On the following falling edge it compares the address and both pipeline fields against a model that it advanced once for that edge. The bench supplies memory contents through an arithmetic function of the address. This lets the expected captured word be computed from the counter value the model held before the edge.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

   typedef enum logic [1:0] {
      NPC_SEQ    = 2'd0,
      NPC_BRANCH = 2'd1,
      NPC_JUMP   = 2'd2
   } npc_src_e;

endpackage

// File: rtl/fetch_npc_sel.sv
module fetch_npc_sel
   import fetch_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int PC_STEP = 4
) (
   input  logic [XLEN-1:0] pc_i,
   input  logic            br_taken_i,
   input  logic [XLEN-1:0] br_target_i,
   input  logic            jmp_i,
   input  logic [XLEN-1:0] jmp_target_i,
   output logic [XLEN-1:0] seq_o,
   output logic [XLEN-1:0] npc_o,
   output logic            redirect_o
);

   localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

   npc_src_e src;

   assign seq_o = pc_i + STEP;

   always_comb begin
      if (jmp_i)           src = NPC_JUMP;
      else if (br_taken_i) src = NPC_BRANCH;
      else                 src = NPC_SEQ;
   end

   always_comb begin
      unique case (src)
         NPC_JUMP:   npc_o = jmp_target_i;
         NPC_BRANCH: npc_o = br_target_i;
         default:    npc_o = seq_o;
      endcase
   end

   assign redirect_o = (src != NPC_SEQ);

endmodule

// File: rtl/fetch_pc_reg.sv
module fetch_pc_reg #(
   parameter int              XLEN       = 32,
   parameter logic [XLEN-1:0] RESET_PC   = '0,
   parameter bit              SYNC_RESET = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic [XLEN-1:0] npc_i,
   output logic [XLEN-1:0] pc_o
);

   generate
      if (SYNC_RESET) begin : g_sync
         always_ff @(posedge clk) begin
            if (!rst_n)      pc_o <= RESET_PC;
            else if (load_i) pc_o <= npc_i;
         end
      end else begin : g_async
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      pc_o <= RESET_PC;
            else if (load_i) pc_o <= npc_i;
         end
      end
   endgenerate

endmodule

// File: rtl/fetch_ifid_reg.sv
module fetch_ifid_reg #(
   parameter int              XLEN       = 32,
   parameter int              ILEN       = 32,
   parameter logic [ILEN-1:0] NOP_WORD   = '0,
   parameter bit              SYNC_RESET = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            stall_i,
   input  logic            squash_i,
   input  logic [XLEN-1:0] link_d,
   input  logic [ILEN-1:0] instr_d,
   output logic [XLEN-1:0] link_q,
   output logic [ILEN-1:0] instr_q
);

   logic [XLEN-1:0] link_n;
   logic [ILEN-1:0] instr_n;

   always_comb begin
      link_n  = link_q;
      instr_n = instr_q;
      if (squash_i) begin
         link_n  = '0;
         instr_n = NOP_WORD;
      end else if (!stall_i) begin
         link_n  = link_d;
         instr_n = instr_d;
      end
   end

   generate
      if (SYNC_RESET) begin : g_sync
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               link_q  <= '0;
               instr_q <= NOP_WORD;
            end else begin
               link_q  <= link_n;
               instr_q <= instr_n;
            end
         end
      end else begin : g_async
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               link_q  <= '0;
               instr_q <= NOP_WORD;
            end else begin
               link_q  <= link_n;
               instr_q <= instr_n;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/fetch_front.sv
module fetch_front #(
   parameter int              XLEN       = 32,
   parameter int              ILEN       = 32,
   parameter int              PC_STEP    = 4,
   parameter logic [XLEN-1:0] RESET_PC   = '0,
   parameter logic [ILEN-1:0] NOP_WORD   = '0,
   parameter bit              SYNC_RESET = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            stall_i,
   input  logic            br_taken_i,
   input  logic [XLEN-1:0] br_target_i,
   input  logic            jmp_i,
   input  logic [XLEN-1:0] jmp_target_i,
   output logic [XLEN-1:0] imem_addr_o,
   input  logic [ILEN-1:0] imem_rdata_i,
   output logic [XLEN-1:0] ifid_pc_plus4_o,
   output logic [ILEN-1:0] ifid_instr_o
);

   localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

   generate
      if (XLEN < 8) begin : g_bad_xlen
         $error("fetch_front: XLEN must be at least 8");
      end
      if (ILEN < 8) begin : g_bad_ilen
         $error("fetch_front: ILEN must be at least 8");
      end
      if (PC_STEP <= 0 || (PC_STEP & (PC_STEP - 1)) != 0) begin : g_bad_step
         $error("fetch_front: PC_STEP must be a positive power of two");
      end
   endgenerate

   logic [XLEN-1:0] pc;
   logic [XLEN-1:0] seq_pc;
   logic [XLEN-1:0] next_pc;
   logic            redirect;
   logic            pc_load;

   fetch_npc_sel #(
      .XLEN    (XLEN),
      .PC_STEP (PC_STEP)
   ) u_sel (
      .pc_i         (pc),
      .br_taken_i   (br_taken_i),
      .br_target_i  (br_target_i),
      .jmp_i        (jmp_i),
      .jmp_target_i (jmp_target_i),
      .seq_o        (seq_pc),
      .npc_o        (next_pc),
      .redirect_o   (redirect)
   );

   assign pc_load = redirect || !stall_i;

   fetch_pc_reg #(
      .XLEN       (XLEN),
      .RESET_PC   (RESET_PC),
      .SYNC_RESET (SYNC_RESET)
   ) u_pc (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (pc_load),
      .npc_i  (next_pc),
      .pc_o   (pc)
   );

   fetch_ifid_reg #(
      .XLEN       (XLEN),
      .ILEN       (ILEN),
      .NOP_WORD   (NOP_WORD),
      .SYNC_RESET (SYNC_RESET)
   ) u_ifid (
      .clk      (clk),
      .rst_n    (rst_n),
      .stall_i  (stall_i),
      .squash_i (redirect),
      .link_d   (seq_pc),
      .instr_d  (imem_rdata_i),
      .link_q   (ifid_pc_plus4_o),
      .instr_q  (ifid_instr_o)
   );

   assign imem_addr_o = pc;

   // Clocked checks on the cooperation of selector, counter and pipeline register
   AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall_i && !br_taken_i && !jmp_i) |=> (imem_addr_o == $past(imem_addr_o) + STEP)); // R3
   AST_SEQ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall_i && !br_taken_i && !jmp_i) |=>
         (ifid_instr_o == $past(imem_rdata_i) && ifid_pc_plus4_o == $past(imem_addr_o) + STEP)); // R3
   AST_BRANCH_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      (br_taken_i && !jmp_i) |=> (imem_addr_o == $past(br_target_i))); // R4
   AST_JUMP_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      jmp_i |=> (imem_addr_o == $past(jmp_target_i))); // R5
   AST_SQUASH_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (br_taken_i || jmp_i) |=> (ifid_instr_o == NOP_WORD && ifid_pc_plus4_o == '0)); // R7
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_i && !br_taken_i && !jmp_i) |=>
         ($stable(imem_addr_o) && $stable(ifid_instr_o) && $stable(ifid_pc_plus4_o))); // R6
   AST_ADDR_IS_PC: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> (imem_addr_o == u_pc.pc_o)); // R2

endmodule

// File: tb/sim_fetch_front.sv
`timescale 1ns/1ps
module sim_fetch_front;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 200000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stall = 1'b0;
   logic        br = 1'b0;
   logic [31:0] br_tgt = '0;
   logic        jmp = 1'b0;
   logic [31:0] jmp_tgt = '0;
   logic [31:0] addr;
   logic [31:0] rdata;
   logic [31:0] link;
   logic [31:0] instr;

   int compared = 0;
   int mismatched = 0;

   logic [31:0] m_pc, m_link, m_instr;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
   endfunction

   assign rdata = mem_word(addr);

   fetch_front u0 (
      .clk             (clk),
      .rst_n           (rst_n),
      .stall_i         (stall),
      .br_taken_i      (br),
      .br_target_i     (br_tgt),
      .jmp_i           (jmp),
      .jmp_target_i    (jmp_tgt),
      .imem_addr_o     (addr),
      .imem_rdata_i    (rdata),
      .ifid_pc_plus4_o (link),
      .ifid_instr_o    (instr)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Apply one cycle of control, advance the model once, compare after the edge
   task automatic step(input logic s, input logic b, input logic [31:0] bt,
                       input logic j, input logic [31:0] jt);
      string tag;
      stall = s; br = b; br_tgt = bt; jmp = j; jmp_tgt = jt;
      if (j)      tag = "R5";
      else if (b) tag = s ? "R7" : "R4";
      else if (s) tag = "R6";
      else        tag = "R3";
      if (j || b) begin
         m_pc    = j ? jt : bt;
         m_link  = '0;
         m_instr = '0;
      end else if (!s) begin
         m_instr = mem_word(m_pc);
         m_link  = m_pc + 32'd4;
         m_pc    = m_pc + 32'd4;
      end
      @(posedge clk);
      @(negedge clk);
      check(tag, "pc", addr, m_pc);
      check(tag, "link", link, m_link);
      check(tag, "instr", instr, m_instr);
      check("R2", "addr echo", addr, m_pc);
   endtask

   initial begin
      #(CLK_PERIOD * WATCHDOG);
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      m_pc = '0; m_link = '0; m_instr = '0;
      repeat (3) @(negedge clk);
      // R1: values while in reset
      check("R1", "pc in reset", addr, 32'h0);
      check("R1", "link in reset", link, 32'h0);
      check("R1", "instr in reset", instr, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      // no stimulus yet was active at the edge after release: stall low -> one advance
      m_instr = mem_word(32'h0); m_link = 32'h4; m_pc = 32'h4;
      check("R3", "first advance pc", addr, m_pc);
      check("R3", "first advance instr", instr, m_instr);

      // Sweep all control combinations with varying targets
      for (int round = 0; round < 8; round++) begin
         for (int k = 0; k < 8; k++) begin
            step(k[0], k[1], 32'h1000_0000 + 32'(round * 68 + k * 4),
                 k[2], 32'h2000_0100 ^ 32'(round * 256 + k * 16));
            step(1'b0, 1'b0, '0, 1'b0, '0);
         end
      end

      // Long stall run followed by release
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 32'hDEAD_BEE0, 1'b0, 32'hCAFE_F00C);
      step(1'b0, 1'b0, '0, 1'b0, '0);

      // R8: wrap from the top of the address space
      step(1'b0, 1'b0, '0, 1'b1, 32'hFFFF_FFFC);
      step(1'b0, 1'b0, '0, 1'b0, '0);
      check("R8", "wrapped pc", addr, 32'h0000_0000);
      check("R8", "wrapped link", link, 32'h0000_0000);
      check("R8", "word from top", instr, mem_word(32'hFFFF_FFFC));

      // R1: reset again from a nonzero state, check first cycle after release
      stall = 1'b1;
      rst_n = 1'b0;
      @(negedge clk);
      check("R1", "pc reassert", addr, 32'h0);
      check("R1", "instr reassert", instr, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "pc held after release", addr, 32'h0);
      check("R1", "link after release", link, 32'h0);
      stall = 1'b0;

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule